// File: doc/BRIEF.md
# DMA Beat Address and Pattern Generator

This block turns the parameters of one DMA transfer into a stream of per-beat bus information. A single start pulse captures the source word, the destination address, the byte count and the attributes of both sides. From the next cycle on it presents one beat at a time. Each beat carries:

- the source address, or a fill pattern;
- the destination address;
- a bus select and a 4-bit command for each side;
- a snoop-enable for each side;
- a byte-enable mask and a last-beat flag.

The consumer takes a beat by raising `beat_take_i` while `beat_valid_o` is high. The block then steps the addresses and counts the remaining bytes down. After the final beat it raises a one-cycle done pulse.

The source is the processor bus, the PCI bus or a constant fill pattern. The fill pattern is either the full source word or its low byte repeated across the beat. Either side can hold its address fixed for the whole transfer. The commands come from the attribute inputs. If a PCI command code is outside the allowed set, the transfer is refused and an illegal-attribute flag is raised.

Top module: `dma_beat_gen`

## Requirements
- R1: A start pulse seen while `beat_valid_o` is low and the attributes are legal loads the transfer. In the next cycle `beat_valid_o` is high and the first beat shows the loaded source and destination addresses.
- R2: Each accepted beat (`beat_valid_o` and `beat_take_i` high together) advances each address that is not held by 4 (BEAT_BYTES).
- R3: A hold bit captured at start (`src_hold_i`, `dst_hold_i`) keeps that side's address constant for the whole transfer.
- R4: `src_type_i` selects the source: 00 is the processor bus (`src_sel_o`=0), 01 is the PCI bus (`src_sel_o`=1), and 1x is a fill pattern (`src_sel_o`=2). With a fill pattern, `fill_o` is the source word, or bits 7:0 of the source word repeated in every byte when `src_byte_fill_i` is set. The pattern stays constant for the whole transfer.
- R5: On the PCI bus, `src_cmd_o` equals `src_cmd_i` for the read codes 0010, 0110, 1100 and 1110. `dst_type_i`=1 selects the PCI bus for the destination, and `dst_cmd_o` then equals `dst_cmd_i` for the write codes 0011, 0111 and 1111.
- R6: A start with a PCI command outside its allowed set issues no beat and sets `illegal_o`. `illegal_o` stays high until the next start that is accepted.
- R7: On the processor bus, `src_cmd_o` is 0000 (plain read), or 0001 (read with intent to modify) when `src_rwitm_i` is set. `dst_type_i`=0 selects the processor bus for the destination, and `dst_cmd_o` is then 0010 (write with kill), or 0011 (write with flush) when `dst_flush_i` is set. A fill source gives `src_cmd_o`=0000.
- R8: `src_snoop_o` is high during beats only when the source is the processor bus and `src_snoop_i` was set. `dst_snoop_o` is high during beats only when the destination is the processor bus and `dst_snoop_i` was set.
- R9: Every beat but the last has `byte_en_o`=1111. The last beat has `last_o` high and its mask enables the low-order bytes for the remaining 1 to 3 bytes (0001, 0011, 0111), or 1111 when the count is a multiple of 4. The number of beats is the count divided by 4, rounded up.
- R10: `done_o` pulses for one cycle, in the cycle after the last beat is taken, and `beat_valid_o` is low in that cycle. A legal start with a count of zero issues no beat and pulses `done_o` in the next cycle.
- R11: A beat that is not taken stays presented unchanged. A start seen while `beat_valid_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, captures all transfer inputs |
| src_addr_i | input | 32 | Source address or fill word |
| dst_addr_i | input | 32 | Destination address |
| byte_cnt_i | input | 16 | Transfer length in bytes |
| src_type_i | input | 2 | Source kind: 00 processor, 01 PCI, 1x fill |
| src_hold_i | input | 1 | Keep source address fixed |
| src_byte_fill_i | input | 1 | Fill pattern is a repeated byte |
| src_cmd_i | input | 4 | PCI read command code |
| src_rwitm_i | input | 1 | Processor read with intent to modify |
| src_snoop_i | input | 1 | Snoop enable for processor-bus reads |
| dst_type_i | input | 1 | Destination kind: 0 processor, 1 PCI |
| dst_hold_i | input | 1 | Keep destination address fixed |
| dst_cmd_i | input | 4 | PCI write command code |
| dst_flush_i | input | 1 | Processor write with flush |
| dst_snoop_i | input | 1 | Snoop enable for processor-bus writes |
| beat_take_i | input | 1 | Consumer takes the presented beat |
| beat_valid_o | output | 1 | A beat is presented |
| src_sel_o | output | 2 | Source select: 0 processor, 1 PCI, 2 fill |
| src_addr_o | output | 32 | Current source address |
| fill_o | output | 32 | Fill pattern for the beat |
| src_cmd_o | output | 4 | Source bus command |
| src_snoop_o | output | 1 | Snoop enable for the source cycle |
| dst_sel_o | output | 1 | Destination select: 0 processor, 1 PCI |
| dst_addr_o | output | 32 | Current destination address |
| dst_cmd_o | output | 4 | Destination bus command |
| dst_snoop_o | output | 1 | Snoop enable for the destination cycle |
| byte_en_o | output | 4 | Byte lanes valid in this beat |
| last_o | output | 1 | This beat is the final one |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| illegal_o | output | 1 | Last start was refused for an illegal command |

## Verification
The assertions assume that reset is applied before the first start. They also assume `beat_take_i` is only treated as meaningful while `beat_valid_o` is high, and that a transfer never runs long enough for an address to wrap. The stimulus keeps counts small and bases far from the top of the address space. It drives `beat_take_i` and `start_i` only between edges. It raises start while a beat is pending only in the test that checks the start is ignored.

// File: rtl/dma_beat_pkg.sv
package dma_beat_pkg;

  typedef enum logic [1:0] {
    SEL_CPU  = 2'd0,
    SEL_PCI  = 2'd1,
    SEL_FILL = 2'd2
  } src_sel_e;

  localparam logic [3:0] CPU_RD     = 4'h0;
  localparam logic [3:0] CPU_RWITM  = 4'h1;
  localparam logic [3:0] CPU_WKILL  = 4'h2;
  localparam logic [3:0] CPU_WFLUSH = 4'h3;

endpackage

// File: rtl/dma_cmd_sel.sv
module dma_cmd_sel #(
  parameter bit WRITE_SIDE = 1'b0
) (
  input  logic       pci_i,
  input  logic       no_bus_i,
  input  logic       qual_i,
  input  logic [3:0] cmd_i,
  output logic [3:0] cmd_o,
  output logic       legal_o
);
  import dma_beat_pkg::*;

  logic       pci_ok;
  logic [3:0] cpu_cmd;

  generate
    if (WRITE_SIDE) begin : g_wr
      always_comb begin
        case (cmd_i)
          4'h3, 4'h7, 4'hF: pci_ok = 1'b1;
          default:          pci_ok = 1'b0;
        endcase
      end
      assign cpu_cmd = qual_i ? CPU_WFLUSH : CPU_WKILL;
    end else begin : g_rd
      always_comb begin
        case (cmd_i)
          4'h2, 4'h6, 4'hC, 4'hE: pci_ok = 1'b1;
          default:                pci_ok = 1'b0;
        endcase
      end
      assign cpu_cmd = qual_i ? CPU_RWITM : CPU_RD;
    end
  endgenerate

  always_comb begin
    if (no_bus_i) begin
      cmd_o   = 4'h0;
      legal_o = 1'b1;
    end else if (pci_i) begin
      cmd_o   = cmd_i;
      legal_o = pci_ok;
    end else begin
      cmd_o   = cpu_cmd;
      legal_o = 1'b1;
    end
  end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          hold_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic [AW-1:0] addr_q;
  logic          hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      hold_q <= 1'b0;
    end else if (load_i) begin
      addr_q <= base_i;
      hold_q <= hold_i;
    end else if (adv_i && !hold_q) begin
      addr_q <= addr_q + INC;
    end
  end

  assign addr_o = addr_q;

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !hold_q && !load_i) |=> (addr_q == $past(addr_q) + INC));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !load_i) |=> $stable(addr_q));

endmodule

// File: rtl/dma_byte_count.sv
module dma_byte_count #(
  parameter int CW = 16,
  parameter int BB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          adv_i,
  output logic          valid_o,
  output logic [BB-1:0] be_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [CW-1:0] BEAT = CW'(BB);

  logic [CW-1:0] remain_q;
  logic [CW-1:0] rem_next;
  logic          valid_q, last_q, done_q;
  logic [BB-1:0] be_q;

  function automatic logic [BB-1:0] mask_of(input logic [CW-1:0] n);
    logic [BB:0] t;
    if (n >= BEAT) begin
      mask_of = '1;
    end else begin
      t = ({{BB{1'b0}}, 1'b1} << n) - 1'b1;
      mask_of = t[BB-1:0];
    end
  endfunction

  assign rem_next = remain_q - BEAT;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      valid_q  <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      be_q     <= '0;
    end else if (load_i) begin
      remain_q <= cnt_i;
      valid_q  <= (cnt_i != '0);
      last_q   <= (cnt_i <= BEAT);
      done_q   <= (cnt_i == '0);
      be_q     <= mask_of(cnt_i);
    end else if (adv_i) begin
      if (last_q) begin
        remain_q <= '0;
        valid_q  <= 1'b0;
        last_q   <= 1'b0;
        done_q   <= 1'b1;
        be_q     <= '0;
      end else begin
        remain_q <= rem_next;
        last_q   <= (rem_next <= BEAT);
        be_q     <= mask_of(rem_next);
        done_q   <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign be_o    = be_q;
  assign last_o  = last_q;
  assign done_o  = done_q;

  // R9
  be_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (be_q != '0));

  // R9
  full_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !last_q) |-> (be_q == {BB{1'b1}}));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !valid_q);

endmodule

// File: rtl/dma_beat_gen.sv
module dma_beat_gen #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [AW-1:0]           src_addr_i,
  input  logic [AW-1:0]           dst_addr_i,
  input  logic [CW-1:0]           byte_cnt_i,
  input  logic [1:0]              src_type_i,
  input  logic                    src_hold_i,
  input  logic                    src_byte_fill_i,
  input  logic [3:0]              src_cmd_i,
  input  logic                    src_rwitm_i,
  input  logic                    src_snoop_i,
  input  logic                    dst_type_i,
  input  logic                    dst_hold_i,
  input  logic [3:0]              dst_cmd_i,
  input  logic                    dst_flush_i,
  input  logic                    dst_snoop_i,
  input  logic                    beat_take_i,
  output logic                    beat_valid_o,
  output logic [1:0]              src_sel_o,
  output logic [AW-1:0]           src_addr_o,
  output logic [8*BEAT_BYTES-1:0] fill_o,
  output logic [3:0]              src_cmd_o,
  output logic                    src_snoop_o,
  output logic                    dst_sel_o,
  output logic [AW-1:0]           dst_addr_o,
  output logic [3:0]              dst_cmd_o,
  output logic                    dst_snoop_o,
  output logic [BEAT_BYTES-1:0]   byte_en_o,
  output logic                    last_o,
  output logic                    done_o,
  output logic                    illegal_o
);
  import dma_beat_pkg::*;

  localparam int DW = 8 * BEAT_BYTES;

  logic       is_fill, accept, legal, load, adv;
  logic       src_legal, dst_legal;
  logic [3:0] src_cmd_d, dst_cmd_d;
  logic       valid;

  logic [1:0] src_sel_q;
  logic [3:0] src_cmd_q, dst_cmd_q;
  logic       dst_sel_q, src_snp_q, dst_snp_q, byte_fill_q, illegal_q;

  assign is_fill = src_type_i[1];
  assign accept  = start_i && !valid;
  assign legal   = src_legal && dst_legal;
  assign load    = accept && legal;
  assign adv     = valid && beat_take_i;

  dma_cmd_sel #(.WRITE_SIDE(1'b0)) u_src_cmd (
    .pci_i   (src_type_i == 2'b01),
    .no_bus_i(is_fill),
    .qual_i  (src_rwitm_i),
    .cmd_i   (src_cmd_i),
    .cmd_o   (src_cmd_d),
    .legal_o (src_legal)
  );

  dma_cmd_sel #(.WRITE_SIDE(1'b1)) u_dst_cmd (
    .pci_i   (dst_type_i),
    .no_bus_i(1'b0),
    .qual_i  (dst_flush_i),
    .cmd_i   (dst_cmd_i),
    .cmd_o   (dst_cmd_d),
    .legal_o (dst_legal)
  );

  dma_addr_step #(.AW(AW), .STEP(BEAT_BYTES)) u_src_step (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .base_i(src_addr_i),
    .hold_i(src_hold_i || is_fill),
    .adv_i (adv),
    .addr_o(src_addr_o)
  );

  dma_addr_step #(.AW(AW), .STEP(BEAT_BYTES)) u_dst_step (
    .clk   (clk),
    .rst   (rst),
    .load_i(load),
    .base_i(dst_addr_i),
    .hold_i(dst_hold_i),
    .adv_i (adv),
    .addr_o(dst_addr_o)
  );

  dma_byte_count #(.CW(CW), .BB(BEAT_BYTES)) u_count (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .cnt_i  (byte_cnt_i),
    .adv_i  (adv),
    .valid_o(valid),
    .be_o   (byte_en_o),
    .last_o (last_o),
    .done_o (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel_q   <= SEL_CPU;
      src_cmd_q   <= 4'h0;
      dst_sel_q   <= 1'b0;
      dst_cmd_q   <= 4'h0;
      src_snp_q   <= 1'b0;
      dst_snp_q   <= 1'b0;
      byte_fill_q <= 1'b0;
      illegal_q   <= 1'b0;
    end else if (accept) begin
      illegal_q <= !legal;
      if (legal) begin
        src_sel_q   <= is_fill ? SEL_FILL : (src_type_i[0] ? SEL_PCI : SEL_CPU);
        src_cmd_q   <= src_cmd_d;
        dst_sel_q   <= dst_type_i;
        dst_cmd_q   <= dst_cmd_d;
        src_snp_q   <= src_snoop_i && (src_type_i == 2'b00);
        dst_snp_q   <= dst_snoop_i && !dst_type_i;
        byte_fill_q <= src_byte_fill_i;
      end
    end
  end

  assign beat_valid_o = valid;
  assign src_sel_o    = src_sel_q;
  assign src_cmd_o    = src_cmd_q;
  assign dst_sel_o    = dst_sel_q;
  assign dst_cmd_o    = dst_cmd_q;
  assign src_snoop_o  = src_snp_q && valid;
  assign dst_snoop_o  = dst_snp_q && valid;
  assign illegal_o    = illegal_q;
  assign fill_o       = byte_fill_q ? {BEAT_BYTES{src_addr_o[7:0]}} : src_addr_o[DW-1:0];

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_q |-> !valid);

  // R11
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && !beat_take_i) |=> (valid && $stable(dst_addr_o) && $stable(byte_en_o)));

  // R8
  snoop_bus_chk: assert property (@(posedge clk) disable iff (rst)
    src_snoop_o |-> (src_sel_o == SEL_CPU));

endmodule

// File: tb/tb_dma_beat_gen.sv
`timescale 1ns/1ps
module tb_dma_beat_gen;

  typedef struct packed {
    logic [1:0]  st;
    logic        sh, sb;
    logic [3:0]  sc;
    logic        sq, ss;
    logic        dt, dh;
    logic [3:0]  dc;
    logic        dq, ds;
    logic [15:0] cnt;
    logic [3:0]  esc, edc;
    logic        ill;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd0,1'b0,1'b0,4'h0,1'b0,1'b1, 1'b1,1'b0,4'h7,1'b0,1'b1, 16'd16, 4'h0,4'h7,1'b0},
    '{2'd1,1'b0,1'b0,4'h6,1'b0,1'b1, 1'b0,1'b0,4'h0,1'b1,1'b1, 16'd10, 4'h6,4'h3,1'b0},
    '{2'd1,1'b1,1'b0,4'hC,1'b0,1'b0, 1'b1,1'b1,4'hF,1'b0,1'b0, 16'd7,  4'hC,4'hF,1'b0},
    '{2'd2,1'b0,1'b0,4'h0,1'b0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b1, 16'd5,  4'h0,4'h2,1'b0},
    '{2'd3,1'b0,1'b1,4'h0,1'b0,1'b0, 1'b1,1'b0,4'h3,1'b0,1'b0, 16'd3,  4'h0,4'h3,1'b0},
    '{2'd0,1'b0,1'b0,4'h0,1'b1,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0, 16'd4,  4'h1,4'h2,1'b0},
    '{2'd1,1'b0,1'b0,4'h7,1'b0,1'b0, 1'b0,1'b0,4'h0,1'b0,1'b0, 16'd8,  4'h0,4'h0,1'b1},
    '{2'd0,1'b0,1'b0,4'h0,1'b0,1'b0, 1'b1,1'b0,4'h6,1'b0,1'b0, 16'd8,  4'h0,4'h0,1'b1},
    '{2'd1,1'b1,1'b0,4'hE,1'b0,1'b0, 1'b1,1'b0,4'h7,1'b0,1'b0, 16'd9,  4'hE,4'h7,1'b0},
    '{2'd1,1'b0,1'b0,4'h2,1'b0,1'b0, 1'b1,1'b1,4'h3,1'b0,1'b0, 16'd12, 4'h2,4'h3,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0;
  logic [15:0] byte_cnt_i = '0;
  logic [1:0]  src_type_i = '0;
  logic        src_hold_i = 1'b0, src_byte_fill_i = 1'b0, src_rwitm_i = 1'b0, src_snoop_i = 1'b0;
  logic [3:0]  src_cmd_i = '0, dst_cmd_i = '0;
  logic        dst_type_i = 1'b0, dst_hold_i = 1'b0, dst_flush_i = 1'b0, dst_snoop_i = 1'b0;
  logic        beat_take_i = 1'b0;
  logic        beat_valid_o, src_snoop_o, dst_sel_o, dst_snoop_o, last_o, done_o, illegal_o;
  logic [1:0]  src_sel_o;
  logic [31:0] src_addr_o, fill_o, dst_addr_o;
  logic [3:0]  src_cmd_o, dst_cmd_o, byte_en_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dma_beat_gen dut (
    .clk(clk), .rst(rst), .start_i(start_i), .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .byte_cnt_i(byte_cnt_i), .src_type_i(src_type_i), .src_hold_i(src_hold_i),
    .src_byte_fill_i(src_byte_fill_i), .src_cmd_i(src_cmd_i), .src_rwitm_i(src_rwitm_i),
    .src_snoop_i(src_snoop_i), .dst_type_i(dst_type_i), .dst_hold_i(dst_hold_i),
    .dst_cmd_i(dst_cmd_i), .dst_flush_i(dst_flush_i), .dst_snoop_i(dst_snoop_i),
    .beat_take_i(beat_take_i), .beat_valid_o(beat_valid_o), .src_sel_o(src_sel_o),
    .src_addr_o(src_addr_o), .fill_o(fill_o), .src_cmd_o(src_cmd_o), .src_snoop_o(src_snoop_o),
    .dst_sel_o(dst_sel_o), .dst_addr_o(dst_addr_o), .dst_cmd_o(dst_cmd_o),
    .dst_snoop_o(dst_snoop_o), .byte_en_o(byte_en_o), .last_o(last_o), .done_o(done_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic [31:0] sa, input logic [31:0] da);
    src_addr_i = sa; dst_addr_i = da; byte_cnt_i = v.cnt;
    src_type_i = v.st; src_hold_i = v.sh; src_byte_fill_i = v.sb; src_cmd_i = v.sc;
    src_rwitm_i = v.sq; src_snoop_i = v.ss;
    dst_type_i = v.dt; dst_hold_i = v.dh; dst_cmd_i = v.dc; dst_flush_i = v.dq; dst_snoop_i = v.ds;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t z;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!beat_valid_o && !done_o && !illegal_o, "R1 reset", {beat_valid_o, done_o, illegal_o}, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] sa, da, ef;
      int nb;
      logic [3:0] lm;
      v  = VT[i];
      sa = 32'h3C5A_10A4 + 32'(i) * 32'h100;
      da = 32'h8000_0000 + 32'(i) * 32'h40;
      nb = (int'(v.cnt) + 3) / 4;
      lm = (v.cnt % 4 == 0) ? 4'hF : 4'((1 << (v.cnt % 4)) - 1);
      ef = v.sb ? {4{sa[7:0]}} : sa;
      apply(v, sa, da);
      if (v.ill) begin
        chk(illegal_o && !beat_valid_o, "R6 illegal", {illegal_o, beat_valid_o}, 2'b10);
        @(negedge clk);
        chk(illegal_o && !beat_valid_o && !done_o, "R6 held", {illegal_o, beat_valid_o, done_o}, 3'b100);
        continue;
      end
      chk(!illegal_o, "R6 clear", illegal_o, 0);
      chk(src_sel_o == (v.st[1] ? 2'd2 : v.st), "R4 sel", src_sel_o, v.st[1] ? 2'd2 : v.st);
      chk(src_cmd_o == v.esc, v.st == 2'd1 ? "R5 src cmd" : "R7 src cmd", src_cmd_o, v.esc);
      chk(dst_cmd_o == v.edc && dst_sel_o == v.dt, v.dt ? "R5 dst cmd" : "R7 dst cmd",
          {dst_sel_o, dst_cmd_o}, {v.dt, v.edc});
      for (int k = 0; k < nb; k++) begin
        logic [31:0] es, ed;
        es = v.sh ? sa : sa + 32'(4 * k);
        ed = v.dh ? da : da + 32'(4 * k);
        chk(beat_valid_o, "R1 valid", beat_valid_o, 1);
        if (v.st[1]) chk(fill_o == ef, "R4 fill", fill_o, ef);
        else chk(src_addr_o == es, v.sh ? "R3 src hold" : "R2 src step", src_addr_o, es);
        chk(dst_addr_o == ed, v.dh ? "R3 dst hold" : "R2 dst step", dst_addr_o, ed);
        chk(src_snoop_o == (v.ss && v.st == 2'd0) && dst_snoop_o == (v.ds && !v.dt), "R8 snoop",
            {src_snoop_o, dst_snoop_o}, {v.ss && v.st == 2'd0, v.ds && !v.dt});
        chk(byte_en_o == ((k == nb - 1) ? lm : 4'hF) && last_o == (k == nb - 1), "R9 mask",
            {last_o, byte_en_o}, {k == nb - 1, (k == nb - 1) ? lm : 4'hF});
        beat_take_i = 1'b1;
        @(negedge clk);
      end
      beat_take_i = 1'b0;
      chk(done_o && !beat_valid_o, "R10 done", {done_o, beat_valid_o}, 2'b10);
      @(negedge clk);
      chk(!done_o, "R10 pulse", done_o, 0);
    end

    // R10 zero count
    z = VT[0];
    z.cnt = 16'd0;
    apply(z, 32'h100, 32'h200);
    chk(done_o && !beat_valid_o, "R10 zero", {done_o, beat_valid_o}, 2'b10);
    @(negedge clk);
    chk(!done_o && !beat_valid_o, "R10 zero end", {done_o, beat_valid_o}, 0);

    // R11 stall and ignored start
    z.cnt = 16'd8;
    z.dh = 1'b0;
    apply(z, 32'h1000, 32'h2000);
    apply(z, 32'h5000, 32'h6000);
    chk(beat_valid_o && dst_addr_o == 32'h2000 && src_addr_o == 32'h1000, "R11 ignore start",
        dst_addr_o, 32'h2000);
    @(negedge clk);
    chk(beat_valid_o && dst_addr_o == 32'h2000 && byte_en_o == 4'hF, "R11 stall", dst_addr_o, 32'h2000);
    beat_take_i = 1'b1;
    @(negedge clk);
    chk(dst_addr_o == 32'h2004 && last_o, "R2 after stall", dst_addr_o, 32'h2004);
    @(negedge clk);
    beat_take_i = 1'b0;
    chk(done_o, "R10 after stall", done_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule